// File: doc/BRIEF.md
# Two-Level Cascaded Interrupt Controller

This block gathers 96 level-sensitive interrupt sources into one CPU interrupt line and an encoded vector naming the source to service first. The sources form three groups of 32: a main-low group (sources 0 to 31), a main-high group (32 to 63) and a general-purpose-pin group (64 to 95). Each group has a cause register and an enable mask. The pin group is not wired to the CPU directly. It feeds four summary bits inside the main-high cause, so its requests reach the CPU through the main-high mask. This is the second level of the cascade.

Software reaches the registers through a plain 32-bit register port with a write strobe and a combinational read path. The port has a window-select pin that picks either the main window or the pin window. Data is little-endian: bit n of any register belongs to source n of its group. A select-cause register answers, in a single read, which main half holds an enabled pending source, and gives the masked cause bits of that half. The interrupt output and the vector are plain level status pins with no handshake. They follow the pending state and need no acknowledge.

Top module: `cascade_intc`

## Requirements
- R1: In the main window, offset 0x04 reads the main-low source levels and offset 0x0C reads the main-high source levels, in the same cycle as the inputs. At bits 27:24 of the main-high value, each bit is the OR of its input line and the matching pin-group summary bit. Writes to 0x04 and 0x0C change nothing.
- R2: A mask bit of 1 enables its source. The masks sit at main 0x14 (low) and 0x1C (high), and at pin-window 0x0C. They take write data on the clock edge where the write strobe is high. After reset, all masks read 0, except the main-high mask, which reads 0x0F000000.
- R3: A pin-group cause bit, read at pin-window offset 0x08, is set on every clock edge where its input is high. It stays set after the input falls.
- R4: A write to pin-window 0x08 clears every cause bit whose write-data bit is 0, and leaves bits written with 1 unchanged. If a pin's input is high on the same edge, that pin's bit stays set.
- R5: Summary bit g (main-high bit 24+g, g = 0..3) is high when any enabled pin-group cause bit among pins 8g to 8g+7 is set.
- R6: Select-cause at main 0x24 behaves as follows. If any enabled main-low cause bit is set, it reads the masked low cause with bit 30 forced to 0. Otherwise, if any enabled main-high bit is set, it reads the masked high cause with bit 30 forced to 1. Otherwise it reads 0.
- R7: irq_out is high exactly when any enabled cause bit is set in either main half.
- R8: irq_vec holds a group code in bits 6:5 (0 low, 1 high, 2 pin group) and a source index in bits 4:0. The main-low group takes precedence, then the main-high group. When an enabled summary bit is set and an enabled pin-group cause exists, the pin group replaces the main-high group. Within the chosen group, the highest-numbered enabled pending bit wins. With nothing pending, irq_vec is 0.
- R9: Any offset not named above reads 0 in either window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| gpp_win | input | 1 | 1 selects the pin-group window, 0 the main window |
| addr | input | 8 | Byte offset inside the selected window |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data of the addressed register |
| main_lo_src | input | 32 | Level inputs of sources 0 to 31 |
| main_hi_src | input | 32 | Level inputs of sources 32 to 63 |
| gpp_src | input | 32 | Level inputs of sources 64 to 95 |
| irq_out | output | 1 | CPU interrupt request |
| irq_vec | output | 7 | Encoded vector of the source to service |

## Verification
Two functions can land on the same clock edge: a write-0 clear of a pin-group cause bit, and that pin's input still being high. The bench provokes this directly. It asserts a pin and, on the same edge, writes a clear that targets that pin and one other set bit. It then expects the driven pin to survive while the other bit is cleared. A second collision is a mask write landing while sources are pending. Random cycles mix mask writes, clear writes and sparse source patterns. After each edge, the bench compares the vector, the select-cause value and the line against a reference model.

// File: rtl/intc_pkg.sv
`timescale 1ns/1ps
package intc_pkg;
  typedef enum logic [1:0] {
    GRP_LO  = 2'd0,
    GRP_HI  = 2'd1,
    GRP_GPP = 2'd2
  } grp_e;

  // main window offsets
  localparam logic [7:0] OFF_CAUSE_LO = 8'h04;
  localparam logic [7:0] OFF_CAUSE_HI = 8'h0C;
  localparam logic [7:0] OFF_MASK_LO  = 8'h14;
  localparam logic [7:0] OFF_MASK_HI  = 8'h1C;
  localparam logic [7:0] OFF_SELECT   = 8'h24;
  // pin-group window offsets
  localparam logic [7:0] OFF_GPP_CAUSE = 8'h08;
  localparam logic [7:0] OFF_GPP_MASK  = 8'h0C;
endpackage

// File: rtl/intc_prio_enc.sv
`timescale 1ns/1ps
module intc_prio_enc #(
  parameter int W = 32,
  localparam int IW = $clog2(W)
) (
  input  logic [W-1:0]  req,
  output logic          any,
  output logic [IW-1:0] idx
);
  always_comb begin
    idx = '0;
    for (int i = 0; i < W; i++) begin
      if (req[i]) idx = IW'(i);
    end
  end
  assign any = |req;
endmodule

// File: rtl/intc_mask_reg.sv
`timescale 1ns/1ps
module intc_mask_reg #(
  parameter int W = 32,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= RST_VAL;
    else if (we) q <= wdata;
  end
endmodule

// File: rtl/intc_gpp_bank.sv
`timescale 1ns/1ps
module intc_gpp_bank #(
  parameter int W = 32,
  parameter int GRPS = 4,
  localparam int PER = W / GRPS
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [W-1:0]    pins,
  input  logic            clr_we,
  input  logic            mask_we,
  input  logic [W-1:0]    wdata,
  output logic [W-1:0]    cause,
  output logic [W-1:0]    mask,
  output logic [W-1:0]    pend,
  output logic [GRPS-1:0] summary
);
  logic [W-1:0] keep;

  // a write clears the bits written as 0; live pins always set
  assign keep = clr_we ? wdata : '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cause <= '0;
    else        cause <= (cause & keep) | pins;
  end

  intc_mask_reg #(.W(W), .RST_VAL('0)) u_mask (
    .clk(clk), .rst_n(rst_n), .we(mask_we), .wdata(wdata), .q(mask)
  );

  assign pend = cause & mask;

  for (genvar g = 0; g < GRPS; g++) begin : g_sum
    assign summary[g] = |pend[g*PER +: PER];
  end
endmodule

// File: rtl/cascade_intc.sv
`timescale 1ns/1ps
module cascade_intc #(
  parameter int W = 32,
  parameter int AW = 8,
  parameter int GPP_GRPS = 4,
  parameter int SUM_LSB = 24,
  parameter int HALF_BIT = 30,
  localparam int IW = $clog2(W),
  localparam int VW = IW + 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          gpp_win,
  input  logic [AW-1:0] addr,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  rdata,
  input  logic [W-1:0]  main_lo_src,
  input  logic [W-1:0]  main_hi_src,
  input  logic [W-1:0]  gpp_src,
  output logic          irq_out,
  output logic [VW-1:0] irq_vec
);
  import intc_pkg::*;

  localparam logic [W-1:0] HI_MASK_RST = W'({GPP_GRPS{1'b1}}) << SUM_LSB;

  logic [W-1:0] mask_lo, mask_hi, gpp_cause, gpp_mask, gpp_pend;
  logic [W-1:0] cause_hi, m_lo, m_hi, sel_val;
  logic [GPP_GRPS-1:0] gpp_sum;
  logic lo_any, hi_any, gpp_any;
  logic [IW-1:0] idx_lo, idx_hi, idx_gpp;

  logic we_mlo, we_mhi, we_gclr, we_gmask;
  assign we_mlo   = wr_en && !gpp_win && (addr == AW'(OFF_MASK_LO));
  assign we_mhi   = wr_en && !gpp_win && (addr == AW'(OFF_MASK_HI));
  assign we_gclr  = wr_en &&  gpp_win && (addr == AW'(OFF_GPP_CAUSE));
  assign we_gmask = wr_en &&  gpp_win && (addr == AW'(OFF_GPP_MASK));

  intc_mask_reg #(.W(W), .RST_VAL('0)) u_mask_lo (
    .clk(clk), .rst_n(rst_n), .we(we_mlo), .wdata(wdata), .q(mask_lo)
  );
  intc_mask_reg #(.W(W), .RST_VAL(HI_MASK_RST)) u_mask_hi (
    .clk(clk), .rst_n(rst_n), .we(we_mhi), .wdata(wdata), .q(mask_hi)
  );

  intc_gpp_bank #(.W(W), .GRPS(GPP_GRPS)) u_gpp (
    .clk(clk), .rst_n(rst_n), .pins(gpp_src), .clr_we(we_gclr),
    .mask_we(we_gmask), .wdata(wdata), .cause(gpp_cause),
    .mask(gpp_mask), .pend(gpp_pend), .summary(gpp_sum)
  );

  // cascade: pin-group summary merges into the high cause
  always_comb begin
    cause_hi = main_hi_src;
    cause_hi[SUM_LSB +: GPP_GRPS] = main_hi_src[SUM_LSB +: GPP_GRPS] | gpp_sum;
  end

  assign m_lo = main_lo_src & mask_lo;
  assign m_hi = cause_hi & mask_hi;

  intc_prio_enc #(.W(W)) u_enc_lo  (.req(m_lo),     .any(lo_any),  .idx(idx_lo));
  intc_prio_enc #(.W(W)) u_enc_hi  (.req(m_hi),     .any(hi_any),  .idx(idx_hi));
  intc_prio_enc #(.W(W)) u_enc_gpp (.req(gpp_pend), .any(gpp_any), .idx(idx_gpp));

  always_comb begin
    sel_val = '0;
    if (lo_any) begin
      sel_val = m_lo;
      sel_val[HALF_BIT] = 1'b0;
    end else if (hi_any) begin
      sel_val = m_hi;
      sel_val[HALF_BIT] = 1'b1;
    end
  end

  always_comb begin
    irq_vec = '0;
    if (lo_any)
      irq_vec = {GRP_LO, idx_lo};
    else if (hi_any) begin
      if ((|m_hi[SUM_LSB +: GPP_GRPS]) && gpp_any)
        irq_vec = {GRP_GPP, idx_gpp};
      else
        irq_vec = {GRP_HI, idx_hi};
    end
  end

  assign irq_out = lo_any | hi_any;

  always_comb begin
    rdata = '0;
    if (gpp_win) begin
      if (addr == AW'(OFF_GPP_CAUSE))     rdata = gpp_cause;
      else if (addr == AW'(OFF_GPP_MASK)) rdata = gpp_mask;
    end else begin
      case (addr)
        AW'(OFF_CAUSE_LO): rdata = main_lo_src;
        AW'(OFF_CAUSE_HI): rdata = cause_hi;
        AW'(OFF_MASK_LO):  rdata = mask_lo;
        AW'(OFF_MASK_HI):  rdata = mask_hi;
        AW'(OFF_SELECT):   rdata = sel_val;
        default:           rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/intc_chk.sv
`timescale 1ns/1ps
module intc_chk #(
  parameter int W = 32,
  parameter int AW = 8,
  parameter int VW = 7,
  parameter int HALF_BIT = 30
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic          gpp_win,
  input logic [AW-1:0] addr,
  input logic [W-1:0]  wdata,
  input logic [W-1:0]  gpp_src,
  input logic [W-1:0]  gpp_cause,
  input logic [W-1:0]  mask_lo,
  input logic [W-1:0]  m_lo,
  input logic [W-1:0]  sel_val,
  input logic          irq_out,
  input logic [VW-1:0] irq_vec
);
  logic clr_wr, mlo_wr;
  assign clr_wr = wr_en && gpp_win && (addr == AW'(8'h08));
  assign mlo_wr = wr_en && !gpp_win && (addr == AW'(8'h14));

  // R4
  gpp_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_wr |=> ((gpp_cause & ~$past(wdata) & ~$past(gpp_src)) == '0));
  // R4
  gpp_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_wr |=> ((gpp_cause & $past(wdata & gpp_cause)) == $past(wdata & gpp_cause)));
  // R3
  gpp_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> ((gpp_cause & $past(gpp_src)) == $past(gpp_src)));
  // R2
  mask_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mlo_wr |=> (mask_lo == $past(wdata)));
  // R8
  vec_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_out |-> (irq_vec == '0));
  // R8
  vec_group_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> (irq_vec[VW-1 -: 2] != 2'd3));
  // R6
  sel_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sel_val[HALF_BIT] |-> (m_lo == '0));
endmodule

bind cascade_intc intc_chk #(.W(W), .AW(AW), .VW(VW), .HALF_BIT(HALF_BIT)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .gpp_win(gpp_win), .addr(addr),
  .wdata(wdata), .gpp_src(gpp_src), .gpp_cause(gpp_cause), .mask_lo(mask_lo),
  .m_lo(m_lo), .sel_val(sel_val), .irq_out(irq_out), .irq_vec(irq_vec)
);

// File: tb/test_cascade_intc.sv
`timescale 1ns/1ps
module test_cascade_intc;
  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, gpp_win = 1'b0;
  logic [7:0] addr = '0;
  logic [31:0] wdata = '0, rdata, lo_src = '0, hi_src = '0, gp_src = '0;
  logic irq_out;
  logic [6:0] irq_vec;
  int checks = 0, fails = 0;
  bit done = 0;

  logic [31:0] mlo, mhi, mg, gc;

  always #10 clk = ~clk;

  cascade_intc i_cascade_intc (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .gpp_win(gpp_win), .addr(addr),
    .wdata(wdata), .rdata(rdata), .main_lo_src(lo_src), .main_hi_src(hi_src),
    .gpp_src(gp_src), .irq_out(irq_out), .irq_vec(irq_vec)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int top_bit(input logic [31:0] x);
    int r = 0;
    for (int i = 0; i < 32; i++) if (x[i]) r = i;
    return r;
  endfunction

  function automatic logic [31:0] e_chi();
    logic [31:0] p = gc & mg;
    logic [31:0] r = hi_src;
    for (int g = 0; g < 4; g++) r[24+g] = hi_src[24+g] | (|p[g*8 +: 8]);
    return r;
  endfunction

  function automatic logic [31:0] e_sel();
    logic [31:0] a = lo_src & mlo, b = e_chi() & mhi;
    if (a != 0) begin a[30] = 1'b0; return a; end
    if (b != 0) begin b[30] = 1'b1; return b; end
    return 32'h0;
  endfunction

  function automatic logic [6:0] e_vec();
    logic [31:0] a = lo_src & mlo, b = e_chi() & mhi, p = gc & mg;
    if (a != 0) return {2'd0, 5'(top_bit(a))};
    if (b != 0) begin
      if ((b[27:24] != 0) && (p != 0)) return {2'd2, 5'(top_bit(p))};
      return {2'd1, 5'(top_bit(b))};
    end
    return 7'h0;
  endfunction

  task automatic rd(input logic gw, input logic [7:0] a, input logic [31:0] exp, input string tag);
    gpp_win = gw; addr = a; #1;
    chk(tag, rdata, exp);
  endtask

  // one clock with an optional write; model advances with it
  task automatic step(input logic wr, input logic gw, input logic [7:0] a, input logic [31:0] d);
    logic [31:0] nlo, nhi, ng, ngc;
    @(negedge clk);
    wr_en = wr; gpp_win = gw; addr = a; wdata = d;
    nlo = mlo; nhi = mhi; ng = mg;
    ngc = (gc & ((wr && gw && a == 8'h08) ? d : 32'hFFFF_FFFF)) | gp_src;
    if (wr && !gw && a == 8'h14) nlo = d;
    if (wr && !gw && a == 8'h1C) nhi = d;
    if (wr && gw && a == 8'h0C) ng = d;
    @(posedge clk); #2;
    wr_en = 1'b0;
    mlo = nlo; mhi = nhi; mg = ng; gc = ngc;
  endtask

  task automatic check_all();
    chk("R7 irq_out", 32'(irq_out), 32'(e_vec() != 0 || (lo_src & mlo) != 0 || (e_chi() & mhi) != 0));
    chk("R8 irq_vec", 32'(irq_vec), 32'(e_vec()));
    rd(1'b0, 8'h24, e_sel(), "R6 select");
    rd(1'b0, 8'h0C, e_chi(), "R1/R5 cause_hi");
    rd(1'b1, 8'h08, gc, "R3 gpp cause");
  endtask

  initial begin
    logic [7:0] offs [8];
    offs = '{8'h04, 8'h0C, 8'h14, 8'h1C, 8'h24, 8'h08, 8'h3C, 8'h10};
    void'($urandom(32'd4711));
    mlo = 0; mhi = 32'h0F00_0000; mg = 0; gc = 0;
    repeat (3) @(posedge clk);
    #3 rst_n = 1'b1;
    #1;
    // reset state
    rd(1'b0, 8'h14, 32'h0, "R2 reset mask_lo");
    rd(1'b0, 8'h1C, 32'h0F00_0000, "R2 reset mask_hi");
    rd(1'b1, 8'h0C, 32'h0, "R2 reset gpp mask");
    chk("R7 reset irq", 32'(irq_out), 32'h0);

    // R9 unmapped offsets
    rd(1'b0, 8'h3C, 32'h0, "R9 main unmapped");
    rd(1'b1, 8'h04, 32'h0, "R9 gpp unmapped");

    // R1 main cause follows inputs, writes ignored
    lo_src = 32'h0000_A005;
    step(1'b1, 1'b0, 8'h04, 32'hFFFF_FFFF);
    rd(1'b0, 8'h04, 32'h0000_A005, "R1 cause_lo after write");
    chk("R7 masked low no irq", 32'(irq_out), 32'h0);

    // R8 low precedence over high; highest index wins
    step(1'b1, 1'b0, 8'h14, 32'h0000_2001);
    hi_src = 32'h8000_0001;
    step(1'b1, 1'b0, 8'h1C, 32'h8F00_0000);
    chk("R8 low first", 32'(irq_vec), {25'h0, 2'd0, 5'd13});
    rd(1'b0, 8'h24, 32'h0000_2001, "R6 both halves report low");
    lo_src = 0; #1;
    chk("R8 high group", 32'(irq_vec), {25'h0, 2'd1, 5'd31});
    rd(1'b0, 8'h24, 32'hC000_0000, "R6 high half flag");

    // R5 GPP cascade, pin 17 -> summary bit 26
    hi_src = 0;
    step(1'b1, 1'b1, 8'h0C, 32'h0002_0010);
    gp_src = 32'h0002_0000;
    step(1'b0, 1'b0, 8'h00, 32'h0);
    gp_src = 0;
    #1;
    rd(1'b0, 8'h0C, 32'h0400_0000, "R5 summary bit 26");
    chk("R8 gpp group", 32'(irq_vec), {25'h0, 2'd2, 5'd17});

    // R4 clear with a simultaneous set on another pin
    gp_src = 32'h0000_0010;
    step(1'b1, 1'b1, 8'h08, ~32'h0002_0010);
    gp_src = 0;
    rd(1'b1, 8'h08, 32'h0000_0010, "R4 set beats clear");
    step(1'b1, 1'b1, 8'h08, 32'hFFFF_FFFF);
    rd(1'b1, 8'h08, 32'h0000_0010, "R4 write ones keep");
    step(1'b1, 1'b1, 8'h08, ~32'h0000_0010);
    rd(1'b1, 8'h08, 32'h0, "R4 one-hot clear");
    check_all();

    // constrained random
    for (int n = 0; n < 400; n++) begin
      logic wr, gw;
      logic [7:0] a;
      logic [31:0] d;
      lo_src = $urandom & $urandom & $urandom;
      hi_src = $urandom & $urandom & $urandom & 32'hF0FF_FFFF;
      gp_src = ($urandom % 4 == 0) ? (32'h1 << ($urandom % 32)) : 32'h0;
      wr = ($urandom % 2) == 1;
      gw = ($urandom % 2) == 1;
      a = offs[$urandom % 8];
      d = $urandom;
      if (gw && a == 8'h08 && ($urandom % 2) == 1) d = ~(32'h1 << ($urandom % 32));
      step(wr, gw, a, d);
      check_all();
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #4_000_000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule